// File: doc/BRIEF.md
# Branch Flow Trace Recorder

The recorder sits beside a processor core and keeps a history of taken changes of program flow. Each time the core redirects its fetch, it offers one capture beat. That beat carries the address the flow left from and the address it went to. Debug software controls the recorder and reads the history back through three registers on a small request/response port: a control word, a status word holding the number of stored entries, and a data window. Each read of the data window removes one word from the history.

Entries are kept last-in first-out in a ring of `DEPTH` slots. The newest jump is returned first. Each entry is returned as two words: the destination first, then the origin. If the ring is full when a new jump arrives, the oldest entry is lost and a sticky overflow flag is raised.

Capture side: `cap_ready` is high exactly when the recorder is both powered and enabled. The core never waits on it. A beat offered while `cap_ready` is low is dropped. Register side: a request is taken on a clock edge where `reg_req_valid` and `reg_req_ready` are both high. Each accepted read produces one `rsp_valid` beat. Writes produce no response. `reg_req_ready` drops for one cycle only when a data-window read has been deferred behind a capture.

Top module: `flow_trace_buf`

## Requirements
- R1: After reset, the control word (address 0) and the status word (address 1) both read 0, and `cap_ready` is low.
- R2: A write to address 0 stores bit 0 (power), bit 1 (enable) and bit 3 (loop compression), and they read back at those positions. Writing 0x3 reads back 0x3 when no overflow is pending, and it makes `cap_ready` high.
- R3: While powered and enabled, each beat with `cap_valid` high adds exactly one entry and raises the status count by one. Idle cycles add nothing.
- R4: Reads of the data window (address 2) return entries newest first.
- R5: Within an entry, the first data read returns the destination address and the second read returns the origin address.
- R6: The status count is unchanged after the first word of an entry is read. It drops by one after the second word is read.
- R7: With power set and enable clear, capture beats are ignored and the stored entries stay readable.
- R8: A capture into a full ring discards the oldest entry. The count stays at `DEPTH` and control bit 2 (overflow) sets.
- R9: The overflow bit stays set until a control write with bit 2 equal to 0. A write with bit 2 equal to 1 leaves it set.
- R10: While the power bit is clear, the ring is empty, the count is 0, and word selection restarts at a destination.
- R11: A data read with no entries stored returns 0 and changes neither the count nor the overflow bit.
- R12: A capture takes priority over a data read accepted in the same cycle. `reg_req_ready` is low on the following cycle and the read is served one cycle later from the updated ring. Any capture restarts word selection at the new entry's destination.
- R13: An accepted read returns `rsp_valid` with its data on the cycle after acceptance, except in the deferred case of R12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | 1 | Taken change of flow this cycle |
| cap_ready | output | 1 | High when captures are being recorded |
| cap_src | input | AW | Address the flow left from |
| cap_dst | input | AW | Address the flow went to |
| reg_req_valid | input | 1 | Register request present |
| reg_req_ready | output | 1 | Register request can be accepted |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | 0 control, 1 status, 2 data window |
| reg_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read response beat |
| rsp_data | output | DW | Read response data |

## Verification
A control, status or data read answers on the cycle after acceptance. A capture shows in the status count one edge after its beat. A control write takes effect on `cap_ready` one edge after acceptance. When a data read collides with a capture, the answer comes two edges later and ready is low in between. The bench drives on falling edges and samples on the next falling edge, which always falls between the edge that registers a result and the edge after it. For the deferred read it waits one extra cycle and also checks the missing response and the low ready at the intermediate sample.

// File: rtl/ftb_pkg.sv
package ftb_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CTL_PWR  = 0;
  localparam int CTL_EN   = 1;
  localparam int CTL_OVF  = 2;
  localparam int CTL_LCMP = 3;
  localparam int CTL_W    = 4;
endpackage

// File: rtl/ftb_ctrl.sv
module ftb_ctrl
  import ftb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          ovf_evt,
  output logic [CTL_W-1:0] ctl
);
  logic pwr_q, en_q, ovf_q, lcmp_q;
  logic unused_hi;

  assign unused_hi = ^wdata[DW-1:CTL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q  <= 1'b0;
      en_q   <= 1'b0;
      ovf_q  <= 1'b0;
      lcmp_q <= 1'b0;
    end else begin
      if (wr_en) begin
        pwr_q  <= wdata[CTL_PWR];
        en_q   <= wdata[CTL_EN];
        lcmp_q <= wdata[CTL_LCMP];
      end
      // overflow: set by hardware, cleared only by writing a zero
      if (ovf_evt)    ovf_q <= 1'b1;
      else if (wr_en) ovf_q <= ovf_q & wdata[CTL_OVF];
    end
  end

  always_comb begin
    ctl           = '0;
    ctl[CTL_PWR]  = pwr_q;
    ctl[CTL_EN]   = en_q;
    ctl[CTL_OVF]  = ovf_q;
    ctl[CTL_LCMP] = lcmp_q;
  end
endmodule

// File: rtl/ftb_lifo.sv
module ftb_lifo #(
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [AW-1:0] push_src,
  input  logic [AW-1:0] push_dst,
  input  logic          pop_word,
  output logic [AW-1:0] top_word,
  output logic [CW-1:0] count,
  output logic          word_sel,
  output logic          drop_evt
);
  logic [AW-1:0] src_q [DEPTH];
  logic [AW-1:0] dst_q [DEPTH];
  logic [PW-1:0] head_q, top_idx;
  logic [CW-1:0] cnt_q;
  logic          ws_q, full;

  assign full     = (cnt_q == CW'(DEPTH));
  assign top_idx  = head_q - PW'(1);
  assign drop_evt = push && full;
  assign count    = cnt_q;
  assign word_sel = ws_q;

  // one write port per slot, selected by the ring head
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && head_q == PW'(g)) begin
        src_q[g] <= push_src;
        dst_q[g] <= push_dst;
      end
    end
  end

  always_comb begin
    if (cnt_q == '0)  top_word = '0;
    else if (ws_q)    top_word = src_q[top_idx];
    else              top_word = dst_q[top_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      head_q <= '0;
      cnt_q  <= '0;
      ws_q   <= 1'b0;
    end else if (push) begin
      head_q <= head_q + PW'(1);
      if (!full) cnt_q <= cnt_q + CW'(1);
      ws_q   <= 1'b0;
    end else if (pop_word && cnt_q != '0) begin
      if (!ws_q) begin
        ws_q <= 1'b1;
      end else begin
        ws_q   <= 1'b0;
        head_q <= top_idx;
        cnt_q  <= cnt_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/flow_trace_buf.sv
module flow_trace_buf
  import ftb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_valid,
  output logic          cap_ready,
  input  logic [AW-1:0] cap_src,
  input  logic [AW-1:0] cap_dst,
  input  logic          reg_req_valid,
  output logic          reg_req_ready,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CTL_W-1:0] ctl;
  logic             power, enable, ovf;
  logic             cap_take, req_fire, data_rd, reg_rd, ctl_wr, pop_now;
  logic             pend_q, drop_evt, word_sel;
  logic [AW-1:0]    top_word;
  logic [CW-1:0]    count;
  reg_sel_e         sel;

  assign sel     = reg_sel_e'(reg_addr);
  assign power   = ctl[CTL_PWR];
  assign enable  = ctl[CTL_EN];
  assign ovf     = ctl[CTL_OVF];

  assign cap_ready     = power && enable;
  assign cap_take      = cap_valid && cap_ready;
  assign reg_req_ready = !pend_q;
  assign req_fire      = reg_req_valid && reg_req_ready;
  assign reg_rd        = req_fire && !reg_we;
  assign data_rd       = reg_rd && sel == SEL_DATA;
  assign ctl_wr        = req_fire && reg_we && sel == SEL_CTRL;
  // capture wins; a colliding pop waits one cycle
  assign pop_now       = (data_rd || pend_q) && !cap_take;

  ftb_ctrl #(.DW(DW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_wr),
    .wdata   (reg_wdata),
    .ovf_evt (drop_evt),
    .ctl     (ctl)
  );

  ftb_lifo #(.AW(AW), .DEPTH(DEPTH)) u_lifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (!power),
    .push     (cap_take),
    .push_src (cap_src),
    .push_dst (cap_dst),
    .pop_word (pop_now),
    .top_word (top_word),
    .count    (count),
    .word_sel (word_sel),
    .drop_evt (drop_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      pend_q    <= (data_rd || pend_q) && cap_take;
      rsp_valid <= pop_now || (reg_rd && sel != SEL_DATA);
      if (pop_now) begin
        rsp_data <= DW'(top_word);
      end else begin
        unique case (sel)
          SEL_CTRL: rsp_data <= DW'(ctl);
          SEL_STAT: rsp_data <= DW'(count);
          default:  rsp_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ftb_checker.sv
module ftb_checker #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_take,
  input logic          data_rd,
  input logic          reg_rd,
  input logic          reg_req_ready,
  input logic          ctl_wr,
  input logic          pop_now,
  input logic          pend_q,
  input logic          power,
  input logic          ovf,
  input logic          word_sel,
  input logic [CW-1:0] count,
  input logic          rsp_valid,
  input logic [31:0]   rsp_data
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R8
  AST_CAP_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_take && count < CW'(DEPTH) |=> count == $past(count) + CW'(1)); // R3
  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_take && count == CW'(DEPTH) |=> ovf && count == CW'(DEPTH)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ctl_wr |=> ovf); // R9
  AST_POWER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !power |=> count == '0 && !word_sel); // R10
  AST_FIRST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pop_now && count != '0 && !word_sel |=> count == $past(count)); // R6
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !cap_take && count == '0 |=> rsp_valid && rsp_data == '0 && count == '0); // R11
  AST_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    cap_take && data_rd |=> !reg_req_ready && !rsp_valid); // R12
  AST_READ_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !(data_rd && cap_take) |=> rsp_valid); // R13
  AST_PEND_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !cap_take |=> rsp_valid && reg_req_ready); // R12
endmodule

bind flow_trace_buf ftb_checker #(.DEPTH(DEPTH), .CW(CW)) u_ftb_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cap_take      (cap_take),
  .data_rd       (data_rd),
  .reg_rd        (reg_rd),
  .reg_req_ready (reg_req_ready),
  .ctl_wr        (ctl_wr),
  .pop_now       (pop_now),
  .pend_q        (pend_q),
  .power         (power),
  .ovf           (ovf),
  .word_sel      (word_sel),
  .count         (count),
  .rsp_valid     (rsp_valid),
  .rsp_data      (32'(rsp_data))
);

// File: tb/flow_trace_buf_bench.sv
`timescale 1ns/1ps
module flow_trace_buf_bench;
  localparam int AW = 32, DW = 32, DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cap_valid = 1'b0, cap_ready;
  logic [AW-1:0] cap_src = '0, cap_dst = '0;
  logic reg_req_valid = 1'b0, reg_req_ready, reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;

  always #4 clk = ~clk;

  flow_trace_buf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_flow_trace_buf (.*);

  int n_chk = 0, n_fail = 0;
  // reference model
  logic [AW-1:0] m_src [DEPTH];
  logic [AW-1:0] m_dst [DEPTH];
  int m_n = 0;
  bit m_ws = 0, m_pwr = 0, m_en = 0, m_ovf = 0, m_lcmp = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ctl();
    return {28'd0, m_lcmp, m_ovf, m_en, m_pwr};
  endfunction

  function automatic void m_push(input logic [AW-1:0] s, input logic [AW-1:0] d);
    if (m_n == DEPTH) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        m_src[i] = m_src[i+1];
        m_dst[i] = m_dst[i+1];
      end
      m_n--;
      m_ovf = 1;
    end
    m_src[m_n] = s;
    m_dst[m_n] = d;
    m_n++;
    m_ws = 0;
  endfunction

  function automatic logic [31:0] m_pop();
    logic [31:0] w;
    if (m_n == 0) return 32'd0;
    w = m_ws ? m_src[m_n-1] : m_dst[m_n-1];
    if (m_ws) m_n--;
    m_ws = !m_ws;
    return w;
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [31:0] w);
    @(negedge clk);
    while (!reg_req_ready) @(negedge clk);
    reg_req_valid = 1; reg_we = 1; reg_addr = a; reg_wdata = w;
    @(negedge clk);
    reg_req_valid = 0; reg_we = 0;
    if (a == 2'd0) begin
      m_pwr = w[0]; m_en = w[1]; m_lcmp = w[3]; m_ovf = m_ovf & w[2];
      if (!m_pwr) begin m_n = 0; m_ws = 0; end
    end
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    while (!reg_req_ready) @(negedge clk);
    reg_req_valid = 1; reg_we = 0; reg_addr = a;
    @(negedge clk);
    reg_req_valid = 0;
    chk(rsp_valid, "R13 response beat", {31'd0, rsp_valid}, 32'd1);
    d = rsp_data;
  endtask

  task automatic cap(input logic [AW-1:0] s, input logic [AW-1:0] d);
    @(negedge clk);
    cap_valid = 1; cap_src = s; cap_dst = d;
    @(negedge clk);
    cap_valid = 0;
    if (m_pwr && m_en) m_push(s, d);
  endtask

  task automatic chk_stat(input string tag);
    logic [31:0] d;
    reg_read(2'd1, d);
    chk(d == m_n, tag, d, m_n);
  endtask

  task automatic chk_ctl(input string tag);
    logic [31:0] d;
    reg_read(2'd0, d);
    chk(d == exp_ctl(), tag, d, exp_ctl());
  endtask

  task automatic chk_data(input string tag);
    logic [31:0] d, e;
    reg_read(2'd2, d);
    e = m_pop();
    chk(d == e, tag, d, e);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R13 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(!cap_ready, "R1 cap_ready after reset", {31'd0, cap_ready}, 0);
    chk_ctl("R1 control after reset");
    chk_stat("R1 status after reset");

    // R2 control storage
    reg_write(2'd0, 32'hB);
    chk_ctl("R2 readback 0xB");
    reg_write(2'd0, 32'h3);
    chk_ctl("R2 readback 0x3");
    chk(cap_ready, "R2 cap_ready on", {31'd0, cap_ready}, 1);

    // R3 three jumps with straight-line gaps
    cap(32'h224, 32'h250); repeat (3) @(negedge clk);
    cap(32'h25a, 32'h234); repeat (2) @(negedge clk);
    cap(32'h23c, 32'h26c);
    chk_stat("R3 three entries");
    // R7 enable cleared keeps contents, blocks capture
    reg_write(2'd0, 32'h1);
    cap(32'hdead, 32'hbeef);
    chk_stat("R7 capture ignored");
    // R4/R5/R6 drain with status after each word
    for (int i = 0; i < 6; i++) begin
      chk_data(i[0] ? "R5 origin word R4" : "R5 destination word R4");
      chk_stat(i[0] ? "R6 count drops after second" : "R6 count holds after first");
    end
    // R11 empty read
    chk_data("R11 empty read zero");
    chk_stat("R11 count unchanged");
    chk_ctl("R11 control unchanged");

    // R8 overflow
    reg_write(2'd0, 32'h3);
    for (int i = 0; i < DEPTH + 2; i++) cap(32'h1000 + i, 32'h2000 + i);
    chk_stat("R8 count saturates");
    chk_ctl("R8 overflow bit");
    for (int i = 0; i < 2 * DEPTH; i++) chk_data("R8 oldest discarded R4");
    // R9 sticky overflow
    reg_write(2'd0, 32'h7);
    chk_ctl("R9 write one keeps overflow");
    reg_write(2'd0, 32'h3);
    chk_ctl("R9 write zero clears overflow");

    // R10 power down mid-entry
    cap(32'h11, 32'h22); cap(32'h33, 32'h44);
    chk_data("R10 pre-power read");
    reg_write(2'd0, 32'h0);
    reg_write(2'd0, 32'h3);
    chk_stat("R10 count cleared");
    chk_data("R10 empty after power");
    cap(32'h55, 32'h66);
    chk_data("R10 word select restarts");

    // R12 mid-entry capture restarts word select
    chk_data("R12 setup origin");
    cap(32'h77, 32'h88);
    chk_data("R12 first word of A");
    cap(32'h99, 32'haa);
    chk_data("R12 new entry destination");

    // R12 collision
    @(negedge clk);
    cap_valid = 1; cap_src = 32'hc0; cap_dst = 32'hd0;
    reg_req_valid = 1; reg_we = 0; reg_addr = 2'd2;
    m_push(32'hc0, 32'hd0);
    @(negedge clk);
    cap_valid = 0; reg_req_valid = 0;
    chk(!reg_req_ready && !rsp_valid, "R12 deferred cycle",
        {30'd0, reg_req_ready, rsp_valid}, 0);
    @(negedge clk);
    begin
      logic [31:0] e;
      e = m_pop();
      chk(rsp_valid && rsp_data == e, "R12 deferred data", rsp_data, e);
    end
    chk_stat("R12 count after collision");

    // random mix
    for (int i = 0; i < 500; i++) begin
      case ($urandom % 10)
        0, 1, 2: cap($urandom, $urandom);
        3, 4:    chk_data("R4 R5 random data");
        5:       chk_stat("R6 random status");
        6:       chk_ctl("R9 random control");
        7:       @(negedge clk);
        8:       if ($urandom % 4 == 0) reg_write(2'd0, 32'h1); else reg_write(2'd0, 32'h3);
        default: case ($urandom % 4)
                   0: reg_write(2'd0, 32'h0);
                   1: reg_write(2'd0, 32'hB);
                   2: reg_write(2'd0, 32'h7);
                   default: reg_read(2'd3, d);
                 endcase
      endcase
    end
    chk_stat("R3 final status");
    chk_ctl("R2 final control");

    summary();
    $finish;
  end
endmodule